// File: doc/BRIEF.md
# Chopper Blanking and Mixed-Decay Timer

This block produces the chopping sequence for one H-bridge of a brushed DC motor driver. A slow oscillator tick (`fcr_tick`, one clock wide per oscillator cycle) paces a period of sixteen ticks. Each period opens in the charge state. The first comparator trip that arrives outside a blanking window moves the bridge into decay. Decay is slow, fast, or a mix: slow decay that turns to fast at a fixed position in the period. The period then runs to its end.

Comparator trips are masked while the programmable blanking window is open at the start of each period. Any level change on the direction input (`phase`) restarts all timing. It first holds a restart interval of two ticks, which is also masked, and then opens the programmable blanking window. All inputs are synchronous to `clk`. The output is a registered two-bit bridge state. A later stage maps it to gate drive.

Top module: `chop_blank_timer`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `bridge_state` is 0 (charge). Leaving reset has the same effect on the timing as a direction change.
- R2: `bridge_state` uses the codes charge = 0, slow decay = 1, fast decay = 2, and never 3. It is registered: it shows the internal state of the previous clock.
- R3: Outside a restart, each `fcr_tick` advances the period position from 0 to 15. The tick at position 15 wraps it to 0, clears any trip and reloads the blanking window, so the next state is charge.
- R4: At every period start the blanking window stays open for `blank_code`+1 ticks (1 to 8). A trip is masked while the window is open.
- R5: A change of `phase` in either direction clears the position, the blanking window and the trip, and starts a restart interval of two ticks. During this interval the position stays 0 and trips are masked. The tick that ends the interval opens the blanking window with `blank_code`+1 ticks.
- R6: The first trip that is not masked moves the state from charge to decay. The state stays in decay until the period wraps or a restart occurs.
- R7: A trip that arrives while masked is ignored and is not remembered once the mask ends.
- R8: `decay_code` 0 gives slow decay only, and `decay_code` 3 gives fast decay only.
- R9: `decay_code` 1 gives slow decay before position 10 and fast decay from position 10 on. `decay_code` 2 switches at position 4. A trip at or after the switch point goes straight to fast.
- R10: When a direction change and a tick fall in the same clock, the direction change wins and the tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fcr_tick | input | 1 | One-clock pulse per oscillator cycle |
| trip | input | 1 | Current-sense comparator, high when the limit is reached |
| phase | input | 1 | Direction level; any change restarts the timing |
| blank_code | input | BLANK_W (3) | Blanking length minus one, in ticks |
| decay_code | input | 2 | 0 slow, 1 mixed late, 2 mixed early, 3 fast |
| bridge_state | output | 2 | 0 charge, 1 slow decay, 2 fast decay |

## Verification
The hardest case to reach is a trip that is masked and then quietly dropped. The trip has to be high throughout a restart interval or a blanking window and fall exactly as the mask lifts. To place it there, one stimulus mode drives `trip` from the bench's own model of the mask. A second case is a direction change in the same clock as a tick. The bench forces this coincidence directly and does not leave it to chance. The remaining runs sweep all four decay codes against short, medium and longest blanking, with random trips and direction changes. A behavioural model is compared on every clock.

// File: rtl/chop_pkg.sv
package chop_pkg;
  typedef enum logic [1:0] {
    BR_CHARGE = 2'd0,
    BR_SLOW   = 2'd1,
    BR_FAST   = 2'd2
  } bridge_e;

  typedef enum logic [1:0] {
    DK_SLOW      = 2'd0,
    DK_MIX_LATE  = 2'd1,
    DK_MIX_EARLY = 2'd2,
    DK_FAST      = 2'd3
  } decay_e;

  function automatic bridge_e pick_state(input logic tripped, input logic past_late,
                                         input logic past_early, input decay_e mode);
    if (!tripped) return BR_CHARGE;
    case (mode)
      DK_SLOW:      return BR_SLOW;
      DK_MIX_LATE:  return past_late ? BR_FAST : BR_SLOW;
      DK_MIX_EARLY: return past_early ? BR_FAST : BR_SLOW;
      default:      return BR_FAST;
    endcase
  endfunction
endpackage

// File: rtl/phase_restart.sv
module phase_restart #(
  parameter int RESET_TICKS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic phase,
  input  logic tick,
  output logic edge_o,
  output logic hold_o,
  output logic release_o
);
  localparam int HW = $clog2(RESET_TICKS + 1);

  logic          phase_q;
  logic [HW-1:0] hold_cnt;

  assign edge_o    = phase ^ phase_q;
  assign hold_o    = (hold_cnt != '0);
  assign release_o = tick && !edge_o && (hold_cnt == HW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= 1'b0;
      hold_cnt <= HW'(RESET_TICKS);
    end else begin
      phase_q <= phase;
      if (edge_o) hold_cnt <= HW'(RESET_TICKS);
      else if (tick && hold_o) hold_cnt <= hold_cnt - HW'(1);
    end
  end

  a_r5_hold_bound: assert property (@(posedge clk) disable iff (rst)
    hold_cnt <= HW'(RESET_TICKS));
  a_r5_edge_restarts: assert property (@(posedge clk) disable iff (rst)
    edge_o |=> hold_cnt == HW'(RESET_TICKS));
endmodule

// File: rtl/period_timer.sv
module period_timer #(
  parameter int PERIOD_TICKS = 16,
  parameter int BLANK_W      = 3
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             edge_i,
  input  logic                             tick,
  input  logic                             hold,
  input  logic                             release_i,
  input  logic [BLANK_W-1:0]               blank_code,
  output logic [$clog2(PERIOD_TICKS)-1:0]  pos_o,
  output logic                             wrap_o,
  output logic                             blank_busy_o
);
  localparam int POS_W = $clog2(PERIOD_TICKS);
  localparam int BL_W  = BLANK_W + 1;
  localparam logic [POS_W-1:0] LAST = POS_W'(PERIOD_TICKS - 1);

  logic [POS_W-1:0] pos;
  logic [BL_W-1:0]  blank_left;
  logic [BL_W-1:0]  blank_load;

  assign blank_load   = BL_W'(blank_code) + BL_W'(1);
  assign wrap_o       = tick && !edge_i && !hold && (pos == LAST);
  assign blank_busy_o = (blank_left != '0);
  assign pos_o        = pos;

  always_ff @(posedge clk) begin
    if (rst || edge_i) begin
      pos        <= '0;
      blank_left <= '0;
    end else if (tick) begin
      if (hold) begin
        if (release_i) blank_load_apply: blank_left <= blank_load;
      end else if (pos == LAST) begin
        pos        <= '0;
        blank_left <= blank_load;
      end else begin
        pos <= pos + POS_W'(1);
        if (blank_busy_o) blank_left <= blank_left - BL_W'(1);
      end
    end
  end

  a_r4_blank_bound: assert property (@(posedge clk) disable iff (rst)
    blank_left <= BL_W'(2 ** BLANK_W));
  a_r3_wrap_reload: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> (pos == '0) && blank_busy_o);
  a_r5_pos_held: assert property (@(posedge clk) disable iff (rst)
    hold |=> pos == '0);
endmodule

// File: rtl/decay_ctrl.sv
module decay_ctrl
  import chop_pkg::*;
#(
  parameter int POS_W      = 4,
  parameter int LATE_POINT = 10,
  parameter int EARLY_POINT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             edge_i,
  input  logic             wrap,
  input  logic             masked,
  input  logic             trip,
  input  logic [POS_W-1:0] pos,
  input  logic [1:0]       decay_code,
  output logic [1:0]       bridge_o
);
  logic    tripped;
  bridge_e state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tripped <= 1'b0;
      state_q <= BR_CHARGE;
    end else begin
      state_q <= pick_state(tripped, pos >= POS_W'(LATE_POINT),
                            pos >= POS_W'(EARLY_POINT), decay_e'(decay_code));
      if (edge_i || wrap) tripped <= 1'b0;
      else if (trip && !masked) tripped <= 1'b1;
    end
  end

  assign bridge_o = state_q;

  a_r2_code_legal: assert property (@(posedge clk) disable iff (rst)
    bridge_o != 2'd3);
  a_r7_masked_ignored: assert property (@(posedge clk) disable iff (rst)
    (!tripped && masked) |=> !tripped);
  a_r6_decay_holds: assert property (@(posedge clk) disable iff (rst)
    (tripped && !wrap && !edge_i) |=> tripped);
  a_r3_wrap_clears: assert property (@(posedge clk) disable iff (rst)
    wrap |=> !tripped);
endmodule

// File: rtl/chop_blank_timer.sv
module chop_blank_timer #(
  parameter int PERIOD_TICKS = 16,
  parameter int BLANK_W      = 3,
  parameter int RESET_TICKS  = 2,
  parameter int LATE_POINT   = 10,
  parameter int EARLY_POINT  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fcr_tick,
  input  logic               trip,
  input  logic               phase,
  input  logic [BLANK_W-1:0] blank_code,
  input  logic [1:0]         decay_code,
  output logic [1:0]         bridge_state
);
  localparam int POS_W = $clog2(PERIOD_TICKS);

  logic             edge_w, hold_w, release_w, wrap_w, blank_busy_w, masked_w;
  logic [POS_W-1:0] pos_w;

  phase_restart #(.RESET_TICKS(RESET_TICKS)) u_restart (
    .clk(clk), .rst(rst), .phase(phase), .tick(fcr_tick),
    .edge_o(edge_w), .hold_o(hold_w), .release_o(release_w)
  );

  period_timer #(.PERIOD_TICKS(PERIOD_TICKS), .BLANK_W(BLANK_W)) u_period (
    .clk(clk), .rst(rst), .edge_i(edge_w), .tick(fcr_tick), .hold(hold_w),
    .release_i(release_w), .blank_code(blank_code), .pos_o(pos_w),
    .wrap_o(wrap_w), .blank_busy_o(blank_busy_w)
  );

  assign masked_w = hold_w | blank_busy_w;

  decay_ctrl #(.POS_W(POS_W), .LATE_POINT(LATE_POINT), .EARLY_POINT(EARLY_POINT)) u_decay (
    .clk(clk), .rst(rst), .edge_i(edge_w), .wrap(wrap_w), .masked(masked_w),
    .trip(trip), .pos(pos_w), .decay_code(decay_code), .bridge_o(bridge_state)
  );

  a_r1_reset_charge: assert property (@(posedge clk)
    $past(rst) |-> bridge_state == 2'd0);
endmodule

// File: tb/chop_blank_timer_bench.sv
module chop_blank_timer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fcr_tick = 1'b0;
  logic       trip = 1'b0;
  logic       phase = 1'b0;
  logic [2:0] blank_code = 3'd0;
  logic [1:0] decay_code = 2'd0;
  logic [1:0] bridge_state;

  int    n_checks = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string cur_req = "R1";
  int    trip_mode = 0;   // 0 low, 1 high, 2 random, 3 high only while model masks
  int    toggle_pct = 0;
  int    tick_div = 4;
  int    cyc = 0;

  // behavioural reference state
  bit m_phq; int m_hold; int m_blank; int m_pos; bit m_tr; int m_out;

  always #5 clk = ~clk;

  chop_blank_timer u_chop_blank_timer (
    .clk(clk), .rst(rst), .fcr_tick(fcr_tick), .trip(trip), .phase(phase),
    .blank_code(blank_code), .decay_code(decay_code), .bridge_state(bridge_state)
  );

  function automatic int expect_out(bit tr, int pos, int mode);
    if (!tr) return 0;
    if (mode == 0) return 1;
    if (mode == 3) return 2;
    if (mode == 1) return (pos >= 10) ? 2 : 1;
    return (pos >= 4) ? 2 : 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_phq = 0; m_hold = 2; m_blank = 0; m_pos = 0; m_tr = 0; m_out = 0;
    end else begin
      bit old_masked, was_wrap;
      old_masked = (m_hold != 0) || (m_blank != 0);
      was_wrap = 0;
      m_out = expect_out(m_tr, m_pos, decay_code);
      if (phase != m_phq) begin
        m_hold = 2; m_blank = 0; m_pos = 0; m_tr = 0;
      end else begin
        if (fcr_tick) begin
          if (m_hold != 0) begin
            if (m_hold == 1) m_blank = blank_code + 1;
            m_hold = m_hold - 1;
          end else if (m_pos == 15) begin
            m_pos = 0; m_blank = blank_code + 1; m_tr = 0; was_wrap = 1;
          end else begin
            m_pos = m_pos + 1;
            if (m_blank != 0) m_blank = m_blank - 1;
          end
        end
        if (trip && !old_masked && !was_wrap) m_tr = 1;
      end
      m_phq = phase;
    end
  end

  task automatic step();
    @(negedge clk);
    n_checks++;
    if (bridge_state !== m_out[1:0]) begin
      n_fail++;
      $display("FAIL %s cycle %0d: bridge_state actual %0d expected %0d",
               cur_req, cyc, bridge_state, m_out);
    end
    cyc++;
    fcr_tick = (cyc % tick_div) == 0;
    case (trip_mode)
      0: trip = 1'b0;
      1: trip = 1'b1;
      2: trip = ($urandom_range(0, 9) < 3);
      default: trip = (m_hold != 0) || (m_blank != 0);
    endcase
    if (toggle_pct != 0 && $urandom_range(0, 999) < toggle_pct) phase = ~phase;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    n_checks++;
    if (bridge_state !== 2'd0) begin   // R1 reset state
      n_fail++;
      $display("FAIL R1: bridge_state actual %0d expected 0", bridge_state);
    end
    rst = 1'b0;
    cur_req = "R1"; trip_mode = 1; run(20);
    // R8 pure slow and pure fast decay
    for (int d = 0; d < 4; d += 3) begin
      decay_code = d[1:0]; cur_req = "R8"; run(300);
    end
    // R9 mixed decay switch points, trips held and random
    for (int d = 1; d < 3; d++) begin
      decay_code = d[1:0]; cur_req = "R9";
      trip_mode = 1; run(300);
      trip_mode = 2; run(300);
    end
    // R4 and R6 blanking lengths with random trips, all decay codes
    for (int b = 0; b < 8; b += 3) begin
      for (int d = 0; d < 4; d++) begin
        blank_code = b[2:0]; decay_code = d[1:0];
        cur_req = (b == 0) ? "R6" : "R4"; trip_mode = 2; run(250);
      end
    end
    blank_code = 3'd7; cur_req = "R4"; trip_mode = 2; run(250);
    // R7 trips present only while masked, restart interval included
    cur_req = "R7"; trip_mode = 3; toggle_pct = 20;
    for (int d = 0; d < 4; d++) begin decay_code = d[1:0]; run(400); end
    // R5 and R3 frequent direction changes, dense ticks
    cur_req = "R5"; trip_mode = 2; toggle_pct = 60; tick_div = 2;
    for (int b = 0; b < 8; b += 2) begin blank_code = b[2:0]; run(400); end
    cur_req = "R3"; toggle_pct = 0; tick_div = 3; decay_code = 2'd1; run(600);
    // R10 direction change in the same clock as a tick
    cur_req = "R10"; tick_div = 4; trip_mode = 1;
    for (int k = 0; k < 6; k++) begin
      while ((cyc + 1) % tick_div != 0) step();
      step();
      phase = ~phase;       // lands with the tick driven in this step
      run(40 + 7 * k);
    end
    cur_req = "R2"; trip_mode = 2; toggle_pct = 5; tick_div = 1; run(1000);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule